// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out a multi-word load or store driven by a 16-bit register-list mask. A start pulse captures a base address, the mask and five control bits: direction (up or down), timing (before or after), base writeback, load versus store, and the privileged S bit. The block then walks the mask from the lowest set index to the highest. It issues one word transfer for each memory acknowledge, reading the register file for stores and writing it for loads.

The start address and the new base are both computed once, from the number of set bits in the mask. The register-15 rules are built in. On a store, register 15 is sent with 4 added to the value read. On a load, register 15 has its two low bits cleared and a pipeline-flush pulse is raised. Privileged behaviour is only signalled: a user-bank select level, or a restore-status pulse.

Top module: `bt_block_xfer`

## Requirements
- R1: When the writeback bit is set and the mask is non-empty, `base_wb_o` pulses in the done cycle with `base_new_o` = base + 4n (direction up) or base − 4n (direction down), where n is the number of set mask bits. With the writeback bit clear, `base_wb_o` stays low.
- R2: The first transfer address depends on the mode. With before=1 and up=1 it is base + 4. With before=1 and up=0 it is base − 4n. With before=0 and up=1 it is base. With before=0 and up=0 it is base − 4n + 4.
- R3: Transfers go in ascending register index, one per acknowledged request (`mem_req_o` && `mem_ack_i` at a rising edge). The address rises by 4 after each transfer. The request, address and data hold steady while the acknowledge is low.
- R4: On loads, bits [1:0] of `mem_addr_o` are always 0. Stores present the address unmodified.
- R5: A store of register 15 drives `mem_wdata_o` = register-file read value + 4. Other registers are stored unchanged.
- R6: A load of register 15 writes `mem_rdata_i` with bits [1:0] cleared to the register file. `pc_flush_o` pulses only in the done cycle of a load whose mask has bit 15 set.
- R7: `user_bank_o` is high during every busy cycle of a store with S=1, or of a load with S=1 whose mask bit 15 is clear. It is low at all other times.
- R8: `restore_status_o` pulses in the done cycle of a load with S=1 and mask bit 15 set. It is never high together with `user_bank_o`.
- R9: `busy_o` rises the cycle after an accepted start and falls in the same cycle that `done_o` pulses for one cycle. The busy time equals the sum of the request cycles. A start while busy is ignored.
- R10: An empty mask gives `done_o` the cycle after the start, with no memory request, no register write and no base writeback.
- R11: After reset, `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; all operands are captured while idle |
| reg_list_i | input | 16 | Register mask, bit i selects register i |
| base_i | input | 32 | Base address |
| up_i | input | 1 | 1 = ascending addresses, 0 = descending |
| before_i | input | 1 | 1 = step before the access, 0 = after |
| wb_i | input | 1 | Write the new base back |
| load_i | input | 1 | 1 = load, 0 = store |
| s_bit_i | input | 1 | Privileged-transfer request |
| busy_o | output | 1 | Transfers in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| base_wb_o | output | 1 | Base writeback strobe |
| base_new_o | output | 32 | Written-back base value |
| pc_flush_o | output | 1 | Register 15 was loaded; flush the pipeline |
| user_bank_o | output | 1 | Select user-bank registers |
| restore_status_o | output | 1 | Restore saved status |

## Verification
The table drives all four address modes, each with a different mask shape. The shapes are a dense low group, a sparse pair, register 15 alone, a full mask, and a single register whose base wraps below zero. Between them these separate the population-count offsets from fixed offsets and show whether the walk runs in ascending order. An unaligned base is run once as a load and once as a store, so address masking that is missing, or applied to stores by mistake, shows up. Register 15 takes part in loads and stores with and without S, which separates the flush, restore and user-bank outputs. Acknowledge stalls of zero to two cycles check that the request holds and that the busy length tracks the number of acknowledges.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } bt_state_e;
endpackage

// File: rtl/bt_lowbit.sv
module bt_lowbit #(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
    any_o = |mask_i;
  end
endmodule

// File: rtl/bt_addr_calc.sv
module bt_addr_calc #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int STEP = 4,
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] list_i,
  input  logic [AW-1:0]   base_i,
  input  logic            up_i,
  input  logic            before_i,
  output logic [CW-1:0]   cnt_o,
  output logic [AW-1:0]   start_o,
  output logic [AW-1:0]   wb_o
);
  logic [AW-1:0] span;

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NREG; i++) cnt_o = cnt_o + CW'(list_i[i]);
  end

  assign span = AW'(cnt_o) * AW'(STEP);

  always_comb begin
    unique case ({before_i, up_i})
      2'b11:   start_o = base_i + AW'(STEP);
      2'b10:   start_o = base_i - span;
      2'b01:   start_o = base_i;
      default: start_o = base_i - span + AW'(STEP);
    endcase
    wb_o = up_i ? base_i + span : base_i - span;
  end
endmodule

// File: rtl/bt_block_xfer.sv
module bt_block_xfer #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW     = $clog2(NREG),
  localparam int CW     = $clog2(NREG + 1),
  localparam int STEP   = DW / 8,
  localparam int PC_IDX = NREG - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic [AW-1:0]   base_i,
  input  logic            up_i,
  input  logic            before_i,
  input  logic            wb_i,
  input  logic            load_i,
  input  logic            s_bit_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_ack_i,
  output logic [IW-1:0]   rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            base_wb_o,
  output logic [AW-1:0]   base_new_o,
  output logic            pc_flush_o,
  output logic            user_bank_o,
  output logic            restore_status_o
);
  import bt_pkg::*;

  bt_state_e       state_q;
  logic [NREG-1:0] mask_q;
  logic [AW-1:0]   addr_q, wb_val_q;
  logic            load_q, s_q, wb_q, pc_in_q, nonempty_q;

  logic [CW-1:0]   cnt;
  logic [AW-1:0]   start_addr, wb_addr;
  logic [IW-1:0]   cur_idx;
  logic            cur_any;
  logic [NREG-1:0] mask_next;
  logic            is_pc, xfer, fire;

  bt_addr_calc #(.AW(AW), .NREG(NREG), .STEP(STEP)) i_addr (
    .list_i(reg_list_i), .base_i(base_i), .up_i(up_i), .before_i(before_i),
    .cnt_o(cnt), .start_o(start_addr), .wb_o(wb_addr)
  );

  bt_lowbit #(.W(NREG)) i_low (
    .mask_i(mask_q), .idx_o(cur_idx), .any_o(cur_any)
  );

  assign xfer      = (state_q == ST_XFER);
  assign fire      = xfer && mem_ack_i;
  assign is_pc     = (cur_idx == IW'(PC_IDX));
  assign mask_next = mask_q & ~(NREG'(1) << cur_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mask_q     <= '0;
      addr_q     <= '0;
      wb_val_q   <= '0;
      load_q     <= 1'b0;
      s_q        <= 1'b0;
      wb_q       <= 1'b0;
      pc_in_q    <= 1'b0;
      nonempty_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mask_q     <= reg_list_i;
          addr_q     <= start_addr;
          wb_val_q   <= wb_addr;
          load_q     <= load_i;
          s_q        <= s_bit_i;
          wb_q       <= wb_i;
          pc_in_q    <= reg_list_i[PC_IDX];
          nonempty_q <= (cnt != '0);
          state_q    <= (cnt != '0) ? ST_XFER : ST_DONE;
        end
        ST_XFER: if (fire) begin
          mask_q <= mask_next;
          addr_q <= addr_q + AW'(STEP);
          if (mask_next == '0) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = xfer;
  assign done_o      = (state_q == ST_DONE);
  assign mem_req_o   = xfer && cur_any;
  assign mem_we_o    = !load_q;
  // word alignment applies to loads only
  assign mem_addr_o  = load_q ? {addr_q[AW-1:2], 2'b00} : addr_q;
  assign rf_raddr_o  = cur_idx;
  assign mem_wdata_o = is_pc ? rf_rdata_i + DW'(STEP) : rf_rdata_i;
  assign rf_we_o     = fire && load_q;
  assign rf_waddr_o  = cur_idx;
  assign rf_wdata_o  = is_pc ? {mem_rdata_i[DW-1:2], 2'b00} : mem_rdata_i;

  assign base_wb_o        = done_o && wb_q && nonempty_q;
  assign base_new_o       = wb_val_q;
  assign pc_flush_o       = done_o && load_q && pc_in_q;
  assign restore_status_o = done_o && load_q && s_q && pc_in_q;
  assign user_bank_o      = xfer && s_q && !(load_q && pc_in_q);

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(rf_raddr_o));
  p_load_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o[1:0] == 2'b00);
  p_flush_in_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_flush_o |-> done_o && !busy_o);
  p_restore_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(restore_status_o && user_bank_o));
  p_busy_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_wb_in_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wb_o |-> done_o);
  p_no_req_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

// File: tb/test_bt_block_xfer.sv
module test_bt_block_xfer;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] reg_list_i = '0;
  logic [31:0] base_i = '0;
  logic up_i = 1'b0, before_i = 1'b0, wb_i = 1'b0, load_i = 1'b0, s_bit_i = 1'b0;
  logic busy_o, done_o, mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o, base_new_o;
  logic [3:0] rf_raddr_o, rf_waddr_o;
  logic rf_we_o, base_wb_o, pc_flush_o, user_bank_o, restore_status_o;

  always #5 clk_i = ~clk_i;

  bt_block_xfer i_bt_block_xfer (.*);

  function automatic logic [31:0] rf_val(logic [3:0] i);
    return 32'hC000_0001 + 32'(i) * 32'h111;
  endfunction
  assign rf_rdata_i  = rf_val(rf_raddr_o);
  assign mem_rdata_i = ~mem_addr_o;

  int checks = 0, errors = 0, cyc = 0;
  int stall_cfg = 0, wait_cnt = 0;
  int n_x = 0, n_rfw = 0, busy_cyc = 0, ub_cyc = 0, done_cnt = 0, stray = 0;
  logic [31:0] l_addr[16], l_wdata[16], l_rfd[16];
  logic [3:0]  l_idx[16], l_rfa[16];
  logic        l_we[16];
  logic        g_wb, g_flush, g_rest;
  logic [31:0] g_new;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // memory / register-file model and monitor
  always @(negedge clk_i) begin
    mem_ack_i = 1'b0;
    if (busy_o) begin
      busy_cyc++;
      if (user_bank_o) ub_cyc++;
    end
    if ((pc_flush_o || restore_status_o || base_wb_o) && !done_o) stray++;
    if (done_o) begin
      done_cnt++;
      g_wb = base_wb_o; g_new = base_new_o; g_flush = pc_flush_o; g_rest = restore_status_o;
    end
    if (mem_req_o) begin
      if (wait_cnt < stall_cfg) wait_cnt++;
      else begin
        wait_cnt = 0;
        mem_ack_i = 1'b1;
        if (n_x < 16) begin
          l_addr[n_x] = mem_addr_o; l_we[n_x] = mem_we_o;
          l_wdata[n_x] = mem_wdata_o; l_idx[n_x] = rf_raddr_o;
        end
        n_x++;
      end
    end
    #1;
    if (rf_we_o) begin
      if (n_rfw < 16) begin l_rfa[n_rfw] = rf_waddr_o; l_rfd[n_rfw] = rf_wdata_o; end
      n_rfw++;
    end
  end

  function automatic int pop(logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic run_op(input logic [15:0] lst, input logic [31:0] b, input logic up, pre, wb,
                        ld, s, input int stall);
    int n, d0, k;
    logic [31:0] st, a, w;
    n = pop(lst);
    stall_cfg = stall; wait_cnt = 0;
    n_x = 0; n_rfw = 0; busy_cyc = 0; ub_cyc = 0; stray = 0;
    d0 = done_cnt;
    @(negedge clk_i);
    reg_list_i = lst; base_i = b; up_i = up; before_i = pre; wb_i = wb; load_i = ld; s_bit_i = s;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (done_cnt == d0) @(negedge clk_i);
    // expected values from the requirements
    case ({pre, up})
      2'b11:   st = b + 4;
      2'b10:   st = b - 32'(4 * n);
      2'b01:   st = b;
      default: st = b - 32'(4 * n) + 4;
    endcase
    chk(n_x == n, "R3 transfer count", 32'(n_x), 32'(n));
    chk(busy_cyc == n * (stall + 1), "R9 busy length", 32'(busy_cyc), 32'(n * (stall + 1)));
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (lst[i] && k < n_x && k < 16) begin
        a = st + 32'(4 * k);
        if (ld) a[1:0] = 2'b00;
        chk(l_addr[k] == a, k == 0 ? "R2 start address" : (ld ? "R4 load address" : "R3 address step"),
            l_addr[k], a);
        chk(l_idx[k] == 4'(i), "R3 ascending order", 32'(l_idx[k]), 32'(i));
        chk(l_we[k] == !ld, "R3 direction", 32'(l_we[k]), 32'(!ld));
        if (!ld) begin
          w = (i == 15) ? rf_val(4'(i)) + 4 : rf_val(4'(i));
          chk(l_wdata[k] == w, i == 15 ? "R5 pc store data" : "R3 store data", l_wdata[k], w);
        end else if (k < n_rfw) begin
          w = ~a;
          if (i == 15) w[1:0] = 2'b00;
          chk(l_rfa[k] == 4'(i) && l_rfd[k] == w, i == 15 ? "R6 pc load data" : "R3 load data",
              l_rfd[k], w);
        end
        k++;
      end
    end
    chk(n_rfw == (ld ? n : 0), "R3 rf writes", 32'(n_rfw), 32'(ld ? n : 0));
    chk(g_wb == (wb && n != 0), "R1 writeback strobe", 32'(g_wb), 32'(wb && n != 0));
    if (wb && n != 0) begin
      w = up ? b + 32'(4 * n) : b - 32'(4 * n);
      chk(g_new == w, "R1 writeback value", g_new, w);
    end
    chk(g_flush == (ld && lst[15]), "R6 flush", 32'(g_flush), 32'(ld && lst[15]));
    chk(g_rest == (ld && s && lst[15]), "R8 restore", 32'(g_rest), 32'(ld && s && lst[15]));
    w = (s && !(ld && lst[15])) ? 32'(busy_cyc) : 32'd0;
    chk(ub_cyc == int'(w), "R7 user bank", 32'(ub_cyc), w);
    chk(stray == 0, "R8 pulses outside done", 32'(stray), 0);
    chk(done_cnt == d0 + 1, "R9 single done", 32'(done_cnt - d0), 1);
  endtask

  localparam int NV = 7;
  localparam logic [15:0] V_LIST [NV] = '{16'h00F1, 16'h8003, 16'h0102, 16'h8000, 16'hFFFF, 16'h0001, 16'h0006};
  localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h2000, 32'h3003, 32'h4000, 32'h5000, 32'h0, 32'h6003};
  localparam logic [4:0]  V_CTL  [NV] = '{5'b11100, 5'b01110, 5'b10011, 5'b00101, 5'b10111, 5'b01100, 5'b00000};
  localparam int          V_STL  [NV] = '{0, 1, 0, 2, 0, 1, 1};

  initial begin
    mem_ack_i = 1'b0;
    #1;
    #30;
    chk(busy_o == 0 && done_o == 0 && mem_req_o == 0 && rf_we_o == 0, "R11 reset state",
        {28'd0, busy_o, done_o, mem_req_o, rf_we_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0, "R11 idle after reset", {30'd0, busy_o, done_o}, 0);

    // ctl = {up, before, wb, load, s}
    for (int v = 0; v < NV; v++)
      run_op(V_LIST[v], V_BASE[v], V_CTL[v][4], V_CTL[v][3], V_CTL[v][2], V_CTL[v][1],
             V_CTL[v][0], V_STL[v]);

    // R10: empty mask
    begin
      int d0;
      d0 = done_cnt; n_x = 0; n_rfw = 0; busy_cyc = 0; g_wb = 1'b0;
      @(negedge clk_i);
      reg_list_i = '0; wb_i = 1'b1; start_i = 1'b1; load_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(done_o == 1'b1 && busy_o == 1'b0, "R10 immediate done", {30'd0, done_o, busy_o}, 32'h2);
      chk(base_wb_o == 1'b0, "R10 no writeback", 32'(base_wb_o), 0);
      @(negedge clk_i);
      chk(n_x == 0 && n_rfw == 0 && busy_cyc == 0, "R10 no access", 32'(n_x + n_rfw + busy_cyc), 0);
      chk(done_cnt == d0 + 1, "R10 single done", 32'(done_cnt - d0), 1);
    end

    // R9: start while busy is ignored
    begin
      int d0;
      d0 = done_cnt; stall_cfg = 2; wait_cnt = 0; n_x = 0; n_rfw = 0;
      @(negedge clk_i);
      reg_list_i = 16'h000F; base_i = 32'h7000; up_i = 1; before_i = 0; wb_i = 1;
      load_i = 0; s_bit_i = 0; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      @(negedge clk_i);
      reg_list_i = 16'hFFFF; base_i = 32'h9000; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      while (done_cnt == d0) @(negedge clk_i);
      chk(n_x == 4, "R9 restart ignored count", 32'(n_x), 4);
      chk(g_new == 32'h7010, "R9 restart ignored base", g_new, 32'h7010);
      @(negedge clk_i);
      @(negedge clk_i);
      chk(n_x == 4 && busy_o == 0, "R9 idle after done", 32'(n_x), 4);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule